// File: doc/BRIEF.md
# Settings Bus Write Assembler

This block sits behind one chip-select of a 16-bit memory-mapped peripheral bus. It turns halfword stores from a processor into full-width writes on a one-way settings bus. Each setting is 32 bits wide, but the processor can only deliver 16 bits per access. It therefore writes the low half of a setting first and the high half second. The block stages the low half and waits for the high half. When the high half arrives, it issues one strobe. That strobe carries the register index and the assembled 32-bit value to every downstream consumer.

Nothing can be read back through this block. The upstream decoder asserts the chip select whenever the access falls inside this slave's window. Only the byte-address bits inside that window reach the block. The window holds 64 settings, with setting n at byte offset 4*n.

Top module: `settings_write_assembler`

## Requirements
- R1: While reset is high, and after it falls, the strobe output, index output and data output are zero. The staged low half is also zero, so a high-half write that follows reset yields data with 0x0000 in bits 15:0.
- R2: A write (select and write enable both high) with address bit 1 = 0 is a low-half write. It loads the staging register and produces no strobe.
- R3: A write with address bit 1 = 1 is a high-half write. It raises the strobe for exactly one cycle, in the cycle after the clock edge that accepted the write.
- R4: On a strobe, bits 31:16 of the data output equal the high-half write data, and bits 15:0 equal the staged low half.
- R5: On a strobe, the 8-bit index output equals byte-address bits 7:2 of the high-half write, zero-extended. This covers indices 0 through 63.
- R6: A high-half write with no low-half write since the last strobe still strobes and reuses the currently staged low half. A strobe never clears the staging register.
- R7: A bus cycle with select low or write enable low is ignored. It produces no strobe and leaves the staged low half unchanged.
- R8: The index comes from the high-half write alone. A preceding low-half write to a different index does not change it.
- R9: Between strobes, the index and data outputs hold their last values.
- R10: Writes on consecutive cycles are all accepted. A low half followed immediately by a high half assembles correctly. Back-to-back high halves produce strobes on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_i | input | 1 | Slave select from the upstream address decoder |
| wr_i | input | 1 | Write enable |
| addr_i | input | 7 | Byte-address bits 7:1 inside the window (bit 1 picks the half) |
| wdata_i | input | 16 | Halfword write data |
| set_stb_o | output | 1 | One-cycle settings strobe |
| set_idx_o | output | 8 | Setting index, valid with the strobe |
| set_val_o | output | 32 | Assembled setting value, valid with the strobe |

## Verification
A corrupted staging register stays hidden until the next high-half write. It then shows up in bits 15:0 of the data on that strobe, one cycle after the write. For that reason, the orphan high-half cases and the ignored-cycle cases each end with a high-half write that exposes the staged value. An error in the half-select or index decode shows up at once: either a strobe appears after a low-half write, or the index is wrong on the very next strobe. A strobe-timing fault shows up as a pulse that is missing, late or stretched, and the bench samples the strobe in the cycle after each write.

// File: rtl/setwr_pkg.sv
package setwr_pkg;

    localparam int HALF_W    = 16;
    localparam int WORD_W    = 2 * HALF_W;
    localparam int IDX_W     = 6;
    localparam int OUT_IDX_W = 8;
    localparam int PAD_W     = OUT_IDX_W - IDX_W;
    localparam int BUS_A_W   = IDX_W + 1;   // byte-address bits [IDX_W+1:1]

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

    typedef struct packed {
        logic              valid;
        half_e             half;
        logic [IDX_W-1:0]  idx;
        logic [HALF_W-1:0] val;
    } bus_req_t;

    typedef struct packed {
        logic                 stb;
        logic [OUT_IDX_W-1:0] idx;
        logic [WORD_W-1:0]    val;
    } setting_t;

    function automatic logic [OUT_IDX_W-1:0] widen_idx(input logic [IDX_W-1:0] i);
        return {{PAD_W{1'b0}}, i};
    endfunction

    function automatic logic [WORD_W-1:0] join_halves(input logic [HALF_W-1:0] hi,
                                                       input logic [HALF_W-1:0] lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/setwr_decode.sv
module setwr_decode
    import setwr_pkg::*;
(
    input  logic                   sel_i,
    input  logic                   wr_i,
    input  logic [BUS_A_W-1:0]     addr_i,
    input  logic [HALF_W-1:0]      wdata_i,
    output bus_req_t               req_o
);
    // addr_i[0] is byte-address bit 1 (half select); addr_i[IDX_W:1] is the word index.
    always_comb begin
        req_o.valid = sel_i && wr_i;
        req_o.half  = addr_i[0] ? HALF_HI : HALF_LO;
        req_o.idx   = addr_i[IDX_W:1];
        req_o.val   = wdata_i;
    end
endmodule

// File: rtl/setwr_stage.sv
module setwr_stage
    import setwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req_i,
    output logic [HALF_W-1:0] lo_o
);
    logic load;
    assign load = req_i.valid && (req_i.half == HALF_LO);

    always_ff @(posedge clk) begin
        if (rst)       lo_o <= '0;
        else if (load) lo_o <= req_i.val;
    end

    logic armed;
    always_ff @(posedge clk) armed <= !rst;

    // R7 / R6: the staged half moves only on a low-half write
    assert_stage_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (armed && !load) |=> $stable(lo_o));
    // R2: a low-half write lands in the staging register
    assert_stage_load_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (lo_o == $past(req_i.val)));
endmodule

// File: rtl/setwr_emit.sv
module setwr_emit
    import setwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req_i,
    input  logic [HALF_W-1:0] lo_i,
    output setting_t          out_o
);
    logic fire;
    assign fire = req_i.valid && (req_i.half == HALF_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_o <= '0;
        end else begin
            out_o.stb <= fire;
            if (fire) begin
                out_o.idx <= widen_idx(req_i.idx);
                out_o.val <= join_halves(req_i.val, lo_i);
            end
        end
    end

    logic armed;
    always_ff @(posedge clk) armed <= !rst;

    // R4: the strobed word is built from the high half and the staged low half
    assert_word_join_R4: assert property (@(posedge clk) disable iff (rst)
        fire |=> (out_o.val == {$past(req_i.val), $past(lo_i)}));
    // R9: the outputs hold between strobes
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (armed && !out_o.stb) |-> ($stable(out_o.val) && $stable(out_o.idx)));
endmodule

// File: rtl/settings_write_assembler.sv
module settings_write_assembler
    import setwr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel_i,
    input  logic                 wr_i,
    input  logic [BUS_A_W-1:0]   addr_i,
    input  logic [HALF_W-1:0]    wdata_i,
    output logic                 set_stb_o,
    output logic [OUT_IDX_W-1:0] set_idx_o,
    output logic [WORD_W-1:0]    set_val_o
);
    bus_req_t          req;
    logic [HALF_W-1:0] staged_lo;
    setting_t          outw;

    setwr_decode u_decode (
        .sel_i   (sel_i),
        .wr_i    (wr_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .req_o   (req)
    );

    setwr_stage u_stage (
        .clk   (clk),
        .rst   (rst),
        .req_i (req),
        .lo_o  (staged_lo)
    );

    setwr_emit u_emit (
        .clk   (clk),
        .rst   (rst),
        .req_i (req),
        .lo_i  (staged_lo),
        .out_o (outw)
    );

    assign set_stb_o = outw.stb;
    assign set_idx_o = outw.idx;
    assign set_val_o = outw.val;

    // R3: a strobe follows only an accepted high-half write
    assert_stb_cause_R3: assert property (@(posedge clk) disable iff (rst)
        set_stb_o |-> $past(sel_i && wr_i && addr_i[0]));
    // R3: every accepted high-half write strobes
    assert_stb_follow_R3: assert property (@(posedge clk) disable iff (rst)
        (sel_i && wr_i && addr_i[0]) |=> set_stb_o);
    // R2: a low-half write never strobes
    assert_lo_silent_R2: assert property (@(posedge clk) disable iff (rst)
        (sel_i && wr_i && !addr_i[0]) |=> !set_stb_o);
    // R7: an idle or unselected cycle never strobes
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !(sel_i && wr_i) |=> !set_stb_o);
    // R5 / R8: the index is the high-half write's word address
    assert_idx_map_R5: assert property (@(posedge clk) disable iff (rst)
        set_stb_o |-> (set_idx_o == {{PAD_W{1'b0}}, $past(addr_i[IDX_W:1])}));
    // R1: outputs are zero in the cycle after reset
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (!set_stb_o && set_idx_o == '0 && set_val_o == '0));
endmodule

// File: tb/settings_write_assembler_tb_top.sv
module settings_write_assembler_tb_top;
    import setwr_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 sel_i, wr_i;
    logic [BUS_A_W-1:0]   addr_i;
    logic [HALF_W-1:0]    wdata_i;
    logic                 set_stb_o;
    logic [OUT_IDX_W-1:0] set_idx_o;
    logic [WORD_W-1:0]    set_val_o;

    int checks   = 0;
    int failures = 0;

    always #5 clk = ~clk;

    settings_write_assembler dut_i (
        .clk(clk), .rst(rst), .sel_i(sel_i), .wr_i(wr_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .set_stb_o(set_stb_o), .set_idx_o(set_idx_o),
        .set_val_o(set_val_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // One bus cycle driven at a falling edge; returns at the next falling edge.
    task automatic cyc(input logic s, input logic w, input int idx,
                       input logic hi, input logic [15:0] d);
        sel_i   = s;
        wr_i    = w;
        addr_i  = {idx[IDX_W-1:0], hi};
        wdata_i = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 0, 1'b0, 16'h0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(); idle();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "stb after reset", {31'b0, set_stb_o}, 32'h0);
        check("R1", "idx after reset", {24'b0, set_idx_o}, 32'h0);
        check("R1", "val after reset", set_val_o, 32'h0);
        cyc(1'b1, 1'b1, 5, 1'b1, 16'hBEEF);
        check("R1", "orphan high after reset stb", {31'b0, set_stb_o}, 32'h1);
        check("R6", "orphan high uses zero low", set_val_o, 32'hBEEF_0000);
        check("R5", "index 5", {24'b0, set_idx_o}, 32'd5);
        idle();
    endtask

    task automatic t_pair();
        cyc(1'b1, 1'b1, 10, 1'b0, 16'h1234);
        check("R2", "low half no strobe", {31'b0, set_stb_o}, 32'h0);
        cyc(1'b1, 1'b1, 10, 1'b1, 16'hABCD);
        check("R3", "high half strobe", {31'b0, set_stb_o}, 32'h1);
        check("R4", "assembled value", set_val_o, 32'hABCD_1234);
        check("R5", "index 10", {24'b0, set_idx_o}, 32'd10);
        idle();
        check("R3", "strobe lasts one cycle", {31'b0, set_stb_o}, 32'h0);
        check("R9", "value held", set_val_o, 32'hABCD_1234);
        check("R9", "index held", {24'b0, set_idx_o}, 32'd10);
    endtask

    task automatic t_orphan();
        cyc(1'b1, 1'b1, 11, 1'b1, 16'h5555);
        check("R6", "orphan reuses staged low", set_val_o, 32'h5555_1234);
        idle();
    endtask

    task automatic t_ignored();
        cyc(1'b0, 1'b1, 1, 1'b0, 16'hFFFF);
        check("R7", "unselected low no strobe", {31'b0, set_stb_o}, 32'h0);
        cyc(1'b1, 1'b0, 1, 1'b0, 16'hEEEE);
        check("R7", "read cycle low no strobe", {31'b0, set_stb_o}, 32'h0);
        cyc(1'b0, 1'b1, 1, 1'b1, 16'hDDDD);
        check("R7", "unselected high no strobe", {31'b0, set_stb_o}, 32'h0);
        cyc(1'b1, 1'b0, 1, 1'b1, 16'hCCCC);
        check("R7", "read cycle high no strobe", {31'b0, set_stb_o}, 32'h0);
        check("R9", "value unchanged by ignored", set_val_o, 32'h5555_1234);
        cyc(1'b1, 1'b1, 2, 1'b1, 16'h0001);
        check("R7", "staged low untouched", set_val_o, 32'h0001_1234);
        idle();
    endtask

    task automatic t_index();
        cyc(1'b1, 1'b1, 3, 1'b0, 16'h0AAA);
        cyc(1'b1, 1'b1, 60, 1'b1, 16'h0BBB);
        check("R8", "index from high write", {24'b0, set_idx_o}, 32'd60);
        check("R4", "cross-index value", set_val_o, 32'h0BBB_0AAA);
        cyc(1'b1, 1'b1, 0, 1'b0, 16'h0F0F);
        cyc(1'b1, 1'b1, 0, 1'b1, 16'hF0F0);
        check("R5", "index 0", {24'b0, set_idx_o}, 32'd0);
        cyc(1'b1, 1'b1, 63, 1'b0, 16'h6363);
        cyc(1'b1, 1'b1, 63, 1'b1, 16'h3636);
        check("R5", "index 63", {24'b0, set_idx_o}, 32'd63);
        check("R4", "value at 63", set_val_o, 32'h3636_6363);
        idle();
    endtask

    task automatic t_back_to_back();
        cyc(1'b1, 1'b1, 20, 1'b0, 16'h1111);
        check("R10", "b2b low no strobe", {31'b0, set_stb_o}, 32'h0);
        cyc(1'b1, 1'b1, 20, 1'b1, 16'h2222);
        check("R10", "b2b first strobe", {31'b0, set_stb_o}, 32'h1);
        check("R10", "b2b first value", set_val_o, 32'h2222_1111);
        cyc(1'b1, 1'b1, 21, 1'b1, 16'h3333);
        check("R10", "b2b second strobe", {31'b0, set_stb_o}, 32'h1);
        check("R10", "b2b second value", set_val_o, 32'h3333_1111);
        check("R10", "b2b second index", {24'b0, set_idx_o}, 32'd21);
        idle();
        check("R3", "b2b strobe drops", {31'b0, set_stb_o}, 32'h0);
    endtask

    task automatic t_reset_mid();
        cyc(1'b1, 1'b1, 7, 1'b0, 16'h7777);
        do_reset();
        check("R1", "outputs cleared by reset", set_val_o, 32'h0);
        cyc(1'b1, 1'b1, 7, 1'b1, 16'h8888);
        check("R1", "reset cleared staged low", set_val_o, 32'h8888_0000);
        idle();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; sel_i = 1'b0; wr_i = 1'b0; addr_i = '0; wdata_i = '0;
        @(negedge clk);
        t_reset();
        t_pair();
        t_orphan();
        t_ignored();
        t_index();
        t_back_to_back();
        t_reset_mid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule